// File: doc/BRIEF.md
# Hiccup Overcurrent Protection Controller

This block supervises one channel of a switching regulator and decides when a persistent overload warrants a full shutdown-and-retry cycle. Once per switching period the power stage raises a tick, together with a flag saying whether the low-side source current limit tripped in that period. A single limit event is tolerated. A run of consecutive limited periods makes the controller turn the channel off and hold it off for a long fixed interval measured in switching periods. It then restarts the channel by requesting a fresh soft-start.

The channel also needs an enable input. Two global fault flags, undervoltage lockout and thermal shutdown, override everything else. The thermal flag arrives as a clean digital level whose hysteresis is handled upstream. Dropping the enable or raising either fault sends the controller to its idle state, where the channel is off and no restart is requested. It stays there until the channel is allowed to run again.

Top module: `hiccup_guard`

## Requirements
- R1: While reset is asserted and directly after it is released, chanOff is 1 and restartPulse is 0.
- R2: In the idle state, a clock edge that samples chanEnable=1, uvloFlag=0 and thermalFlag=0 puts the channel in the running state, and chanOff is 0 from that edge on. This start issues no restartPulse.
- R3: While running, the clock edge that samples the TRIP_COUNT-th consecutive tick with limitHit=1 enters hiccup, and chanOff is 1 from that edge on.
- R4: A tick with limitHit=0 sets the consecutive-limit count back to zero. A clock with cycleTick=0 neither counts nor clears, whatever limitHit shows.
- R5: Hiccup lasts exactly OFF_CYCLES ticks after the entering tick. The edge that samples the OFF_CYCLES-th tick returns the channel to running, which drops chanOff, and raises restartPulse for exactly one clock.
- R6: While in hiccup, limitHit has no effect on the length of the off interval.
- R7: A clock edge that samples chanEnable=0, whether the controller is running or in hiccup, moves it to idle. chanOff is 1 from that edge, the pending timeout is discarded, and no restartPulse follows.
- R8: A clock edge that samples uvloFlag=1 forces idle in any state. chanOff stays 1 and no restartPulse occurs while the flag is high.
- R9: A clock edge that samples thermalFlag=1 forces idle in any state, as in R8. Clearing the flag lets the channel run again with its limit count at zero.
- R10: After a restart, and after any return from idle, the consecutive-limit count starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycleTick | input | 1 | One-clock strobe, once per switching period |
| limitHit | input | 1 | Source current limit reached in this period; read only with cycleTick |
| chanEnable | input | 1 | Channel enable |
| uvloFlag | input | 1 | Supply undervoltage lockout active |
| thermalFlag | input | 1 | Thermal shutdown active |
| chanOff | output | 1 | Channel drivers must stay off |
| restartPulse | output | 1 | One-clock request for a new soft-start after hiccup |

## Verification
A streak count that is off by one shows at the ports on the very tick where the trip should or should not happen, because chanOff changes on that edge. An off-interval count that is wrong moves the edge where chanOff falls together with restartPulse by whole ticks. This makes the error visible within one off interval of the trip. An idle or fault path that leaves state behind shows up only later: either as a restartPulse while disabled, or as an early trip after the channel is re-enabled. For that reason the bench always follows such a path with a fresh limit run.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_HICCUP = 2'd2
  } hiccupState_t;

  // Strobes from the control FSM to the counter datapath.
  typedef struct packed {
    logic clrStreak;
    logic incStreak;
    logic clrOff;
    logic incOff;
  } counterStrobe_t;

endpackage

// File: rtl/hiccup_gate.sv
module hiccup_gate (
  input  logic chanEnable,
  input  logic uvloFlag,
  input  logic thermalFlag,
  output logic runAllowed
);
  logic faultActive;

  always_comb begin
    faultActive = uvloFlag | thermalFlag;
    runAllowed  = chanEnable & ~faultActive;
  end
endmodule

// File: rtl/hiccup_counters.sv
module hiccup_counters
  import hiccup_pkg::*;
#(
  parameter int TRIP_COUNT = 7,
  parameter int OFF_CYCLES = 7936
) (
  input  logic           clk,
  input  logic           rst_n,
  input  counterStrobe_t strobe,
  output logic           streakAtEdge,
  output logic           offAtEdge
);
  localparam int STREAK_W = (TRIP_COUNT > 1) ? $clog2(TRIP_COUNT) : 1;
  localparam int OFF_W    = (OFF_CYCLES > 1) ? $clog2(OFF_CYCLES) : 1;
  localparam logic [STREAK_W-1:0] STREAK_LAST = STREAK_W'(TRIP_COUNT - 1);
  localparam logic [OFF_W-1:0]    OFF_LAST    = OFF_W'(OFF_CYCLES - 1);

  logic [OFF_W-1:0] offCount;

  // Consecutive-limit streak: a single-event trip needs no register.
  generate
    if (TRIP_COUNT > 1) begin : g_streak
      logic [STREAK_W-1:0] streakCount;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                streakCount <= '0;
        else if (strobe.clrStreak) streakCount <= '0;
        else if (strobe.incStreak && streakCount != STREAK_LAST)
          streakCount <= streakCount + 1'b1;
      end
      assign streakAtEdge = (streakCount == STREAK_LAST);
    end else begin : g_single
      assign streakAtEdge = 1'b1;
    end
  endgenerate

  // Off-time counter for the hiccup interval.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             offCount <= '0;
    else if (strobe.clrOff) offCount <= '0;
    else if (strobe.incOff && offCount != OFF_LAST)
      offCount <= offCount + 1'b1;
  end

  assign offAtEdge = (offCount == OFF_LAST);
endmodule

// File: rtl/hiccup_fsm.sv
module hiccup_fsm
  import hiccup_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           runAllowed,
  input  logic           cycleTick,
  input  logic           limitHit,
  input  logic           streakAtEdge,
  input  logic           offAtEdge,
  output counterStrobe_t strobe,
  output hiccupState_t   state,
  output logic           restartPulse
);
  hiccupState_t nextState;
  logic         restartNext;

  always_comb begin
    nextState   = state;
    strobe      = '0;
    restartNext = 1'b0;
    unique case (state)
      ST_IDLE: begin
        strobe.clrStreak = 1'b1;
        strobe.clrOff    = 1'b1;
        if (runAllowed) nextState = ST_RUN;
      end
      ST_RUN: begin
        if (!runAllowed) begin
          nextState        = ST_IDLE;
          strobe.clrStreak = 1'b1;
        end else if (cycleTick) begin
          if (!limitHit) begin
            strobe.clrStreak = 1'b1;
          end else if (streakAtEdge) begin
            nextState        = ST_HICCUP;
            strobe.clrStreak = 1'b1;
            strobe.clrOff    = 1'b1;
          end else begin
            strobe.incStreak = 1'b1;
          end
        end
      end
      ST_HICCUP: begin
        if (!runAllowed) begin
          nextState     = ST_IDLE;
          strobe.clrOff = 1'b1;
        end else if (cycleTick) begin
          if (offAtEdge) begin
            nextState        = ST_RUN;
            strobe.clrOff    = 1'b1;
            strobe.clrStreak = 1'b1;
            restartNext      = 1'b1;
          end else begin
            strobe.incOff = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      restartPulse <= 1'b0;
    end else begin
      state        <= nextState;
      restartPulse <= restartNext;
    end
  end
endmodule

// File: rtl/hiccup_guard.sv
module hiccup_guard
  import hiccup_pkg::*;
#(
  parameter int TRIP_COUNT = 7,
  parameter int OFF_CYCLES = 7936
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cycleTick,
  input  logic limitHit,
  input  logic chanEnable,
  input  logic uvloFlag,
  input  logic thermalFlag,
  output logic chanOff,
  output logic restartPulse
);
  logic           runAllowed;
  logic           streakAtEdge;
  logic           offAtEdge;
  counterStrobe_t strobe;
  hiccupState_t   state;

  hiccup_gate u_gate (
    .chanEnable (chanEnable),
    .uvloFlag   (uvloFlag),
    .thermalFlag(thermalFlag),
    .runAllowed (runAllowed)
  );

  hiccup_counters #(
    .TRIP_COUNT(TRIP_COUNT),
    .OFF_CYCLES(OFF_CYCLES)
  ) u_counters (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .streakAtEdge(streakAtEdge),
    .offAtEdge   (offAtEdge)
  );

  hiccup_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .runAllowed  (runAllowed),
    .cycleTick   (cycleTick),
    .limitHit    (limitHit),
    .streakAtEdge(streakAtEdge),
    .offAtEdge   (offAtEdge),
    .strobe      (strobe),
    .state       (state),
    .restartPulse(restartPulse)
  );

  assign chanOff = (state != ST_RUN);
endmodule

// File: rtl/hiccup_guard_checker.sv
module hiccup_guard_checker (
  input logic clk,
  input logic rst_n,
  input logic cycleTick,
  input logic limitHit,
  input logic chanEnable,
  input logic uvloFlag,
  input logic thermalFlag,
  input logic chanOff,
  input logic restartPulse
);
  logic okToRun;
  assign okToRun = chanEnable & ~uvloFlag & ~thermalFlag;

  // R1: out of reset the channel is held off
  always_comb begin
    if (!rst_n) assert_reset_off_R1: assert (chanOff && !restartPulse);
  end

  // R5: restart request lasts one clock and coincides with the channel running
  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restartPulse |=> !restartPulse);
  assert_pulse_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restartPulse |-> !chanOff && $past(chanOff) && $past(cycleTick));

  // R3: a running channel only shuts itself down on a limited tick
  assert_trip_on_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(chanOff) && $past(okToRun)) |-> $past(cycleTick && limitHit));

  // R2: a start from idle never raises the restart request
  assert_quiet_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(chanOff) && !restartPulse) |-> $past(okToRun));

  // R7: disable forces off with no restart
  assert_disable_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !chanEnable |=> chanOff && !restartPulse);

  // R8: undervoltage forces off with no restart
  assert_uvlo_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    uvloFlag |=> chanOff && !restartPulse);

  // R9: thermal shutdown forces off with no restart
  assert_thermal_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    thermalFlag |=> chanOff && !restartPulse);
endmodule

bind hiccup_guard hiccup_guard_checker u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cycleTick   (cycleTick),
  .limitHit    (limitHit),
  .chanEnable  (chanEnable),
  .uvloFlag    (uvloFlag),
  .thermalFlag (thermalFlag),
  .chanOff     (chanOff),
  .restartPulse(restartPulse)
);

// File: tb/hiccup_guard_test.sv
`timescale 1ns/1ps
module hiccup_guard_test;
  localparam int TRIP = 3;
  localparam int OFFC = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cycleTick = 1'b0;
  logic limitHit = 1'b0;
  logic chanEnable = 1'b0;
  logic uvloFlag = 1'b0;
  logic thermalFlag = 1'b0;
  logic chanOff;
  logic restartPulse;

  int checkCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  hiccup_guard #(.TRIP_COUNT(TRIP), .OFF_CYCLES(OFFC)) uut (
    .clk(clk), .rst_n(rst_n), .cycleTick(cycleTick), .limitHit(limitHit),
    .chanEnable(chanEnable), .uvloFlag(uvloFlag), .thermalFlag(thermalFlag),
    .chanOff(chanOff), .restartPulse(restartPulse)
  );

  task automatic expectOut(input logic expOff, input logic expPulse, input string req);
    checkCount++;
    if (chanOff !== expOff || restartPulse !== expPulse) begin
      failCount++;
      $display("FAIL %s: chanOff=%0b restartPulse=%0b expected %0b/%0b",
               req, chanOff, restartPulse, expOff, expPulse);
    end
  endtask

  // One tick; outputs sampled at the negedge after the capturing edge.
  task automatic doTick(input logic lim);
    @(negedge clk);
    cycleTick = 1'b1;
    limitHit  = lim;
    @(negedge clk);
    cycleTick = 1'b0;
    limitHit  = 1'b0;
  endtask

  // A clock without tick, with a chosen limitHit level.
  task automatic gapClock(input logic lim);
    @(negedge clk);
    limitHit = lim;
    @(negedge clk);
    limitHit = 1'b0;
  endtask

  task automatic setEnable(input logic v);
    @(negedge clk);
    chanEnable = v;
    @(negedge clk);
  endtask

  task automatic tripNow();
    for (int i = 0; i < TRIP; i++) doTick(1'b1);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: run did not complete");
      finishRun();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    expectOut(1'b1, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    expectOut(1'b1, 1'b0, "R1 after reset, disabled");

    // R2: start from idle
    setEnable(1'b1);
    expectOut(1'b0, 1'b0, "R2 start");

    // R3/R4/R7: sweep all 6-tick limit patterns with gap clocks in between
    for (int pat = 0; pat < 64; pat++) begin
      int streak = 0;
      bit tripped = 1'b0;
      for (int b = 0; b < 6 && !tripped; b++) begin
        logic lim;
        lim = pat[b];
        doTick(lim);
        streak = lim ? streak + 1 : 0;
        if (streak == TRIP) tripped = 1'b1;
        expectOut(tripped, 1'b0, tripped ? "R3 trip" : "R4 streak");
        if (!tripped) begin
          gapClock(logic'(pat[0] ^ b[0]));
          expectOut(1'b0, 1'b0, "R4 gap clock");
        end
      end
      setEnable(1'b0);
      expectOut(1'b1, 1'b0, "R7 disable");
      setEnable(1'b1);
      expectOut(1'b0, 1'b0, "R10 re-enable");
    end

    // R5/R6: full hiccup interval with limit flags toggling
    tripNow();
    expectOut(1'b1, 1'b0, "R3 trip before hiccup");
    for (int i = 1; i < OFFC; i++) begin
      doTick(logic'(i % 2));
      expectOut(1'b1, 1'b0, "R6 hiccup holding");
      gapClock(1'b1);
    end
    doTick(1'b1);
    expectOut(1'b0, 1'b1, "R5 restart");
    @(negedge clk);
    expectOut(1'b0, 1'b0, "R5 single pulse");

    // R10: streak starts from zero after restart
    doTick(1'b1); doTick(1'b1);
    expectOut(1'b0, 1'b0, "R10 fresh streak");
    doTick(1'b0);
    doTick(1'b1); doTick(1'b1);
    expectOut(1'b0, 1'b0, "R4 cleared streak");
    doTick(1'b1);
    expectOut(1'b1, 1'b0, "R3 trip again");

    // R7: abort hiccup by disable, no restart afterwards
    doTick(1'b0); doTick(1'b0);
    setEnable(1'b0);
    expectOut(1'b1, 1'b0, "R7 abort");
    for (int i = 0; i < OFFC + 2; i++) begin
      doTick(1'b0);
      expectOut(1'b1, 1'b0, "R7 no restart while disabled");
    end
    setEnable(1'b1);
    expectOut(1'b0, 1'b0, "R7 re-enable after abort");

    // R8: undervoltage in run and in hiccup
    @(negedge clk); uvloFlag = 1'b1; @(negedge clk);
    expectOut(1'b1, 1'b0, "R8 uvlo in run");
    @(negedge clk); uvloFlag = 1'b0; @(negedge clk);
    expectOut(1'b0, 1'b0, "R8 uvlo cleared");
    tripNow();
    @(negedge clk); uvloFlag = 1'b1; @(negedge clk);
    for (int i = 0; i < OFFC + 2; i++) begin
      doTick(1'b0);
      expectOut(1'b1, 1'b0, "R8 uvlo in hiccup");
    end
    @(negedge clk); uvloFlag = 1'b0; @(negedge clk);
    expectOut(1'b0, 1'b0, "R8 recover without pulse");

    // R9: thermal shutdown clears streak
    doTick(1'b1); doTick(1'b1);
    @(negedge clk); thermalFlag = 1'b1; @(negedge clk);
    expectOut(1'b1, 1'b0, "R9 thermal off");
    doTick(1'b1);
    expectOut(1'b1, 1'b0, "R9 thermal holds");
    @(negedge clk); thermalFlag = 1'b0; @(negedge clk);
    expectOut(1'b0, 1'b0, "R9 thermal cleared");
    doTick(1'b1);
    expectOut(1'b0, 1'b0, "R9 streak restarted");

    finished = 1'b1;
    finishRun();
  end
endmodule